// File: doc/BRIEF.md
# Interrupt Mask and Output Port Unit

This unit sits on the byte-wide host register bus of a multi-channel serial controller. It gathers the transmit-ready and receive-ready conditions of every channel into one interrupt status byte. It gates that byte with a host-written mask and drives an active-low interrupt request whenever an unmasked condition is present. Status is read at the same offset that takes the mask on a write.

The unit also owns a general-purpose output port. The host never writes the port value directly: one offset sets every bit written as 1, and another clears every bit written as 1. The pins drive the complement of the port register, so a cleared register leaves the pins high. A configuration byte for the output pins is stored for neighbouring logic to decode. The input pins are synchronised and can be read raw, so the host inverts them to get the asserted level. For the low pins there is also a change register that flags transitions until it is read. A read at the set offset also starts the shared counter through a one-cycle strobe.

Top module: `irq_outport_unit`

## Requirements
- R1: A read at offset 0x5 returns the live status: channel x transmit-ready at bit 4x, channel x receive-ready at bit 4x+1, and every other bit 0.
- R2: A write at offset 0x5 loads the interrupt mask, using the same bit positions as the status. A later read at 0x5 still returns the status and never the mask.
- R3: irqN is low in the cycle after any bit of (status AND mask) is 1 and high in the cycle after none is. It therefore rises again once the source condition goes away.
- R4: A write at offset 0xE sets each output-port bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R5: A write at offset 0xF clears each output-port bit whose data bit is 1. Bits whose data bit is 0 keep their value.
- R6: outPins always equals the complement of the output-port register, which resets to 0 (all pins high). Writes at any offset other than 0xE and 0xF leave outPins unchanged.
- R7: A write at offset 0xD stores the byte on opCfg, which resets to 0. A read at 0xD returns the input pins after a two-stage synchroniser, zero-extended to 8 bits.
- R8: A read at offset 0x4 returns the synchronised levels of the four low pins in bits 3:0 and their change flags in bits 7:4. A flag is set by any transition of its pin and cleared by this read. A transition detected in the same cycle as the clearing read keeps its flag set.
- R9: A read at offset 0xE drives ctrStart high for exactly the following cycle. A write at 0xE in the same cycle still applies its set to the output port.
- R10: Read data is registered: busRdata takes the addressed value in the cycle after busRd and holds it while busRd is low. Reads at unmapped offsets, and at 0xE and 0xF, return 0.
- R11: After reset the mask is 0, irqN is high, opCfg is 0, busRdata is 0 and ctrStart is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Register offset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Registered read data |
| chanTxRdy | input | NUM_CH | Transmit-ready condition per channel |
| chanRxRdy | input | NUM_CH | Receive-ready condition per channel |
| inPins | input | IN_W | Asynchronous input pins, active low |
| outPins | output | OUT_W | Output pins, complement of the port register |
| opCfg | output | 8 | Stored output-pin configuration byte |
| ctrStart | output | 1 | One-cycle counter start strobe |
| irqN | output | 1 | Interrupt request, active low |

## Verification
The bench builds the unit with NUM_CH=2, IN_W=6, OUT_W=8 and CHG_PINS=4. With two channels, both 4-bit status groups fill the whole byte, so the upper channel's positions at bits 4 and 5 get exercised. The full 8-bit output port makes every set and clear data bit visible on a pin. With six input pins, the raw input read can be told apart from the four-pin change register, and the read-clear race on one pin can be timed exactly through the two synchroniser stages.

// File: rtl/irq_outport_pkg.sv
package irq_outport_pkg;

  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFF_CHANGE = 4'h4;
  localparam logic [ADDR_W-1:0] OFF_IRQ    = 4'h5;
  localparam logic [ADDR_W-1:0] OFF_INPORT = 4'hD;
  localparam logic [ADDR_W-1:0] OFF_OPSET  = 4'hE;
  localparam logic [ADDR_W-1:0] OFF_OPCLR  = 4'hF;

  typedef enum logic [1:0] {
    RD_NONE,
    RD_STATUS,
    RD_CHANGE,
    RD_INPORT
  } rdSel_e;

  typedef struct packed {
    logic   wrMask;
    logic   wrCfg;
    logic   setOut;
    logic   clrOut;
    logic   rdEn;
    rdSel_e rdSel;
    logic   clrChange;
    logic   ctrStart;
  } strobes_t;

endpackage

// File: rtl/irq_outport_ctrl.sv
module irq_outport_ctrl
  import irq_outport_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  output strobes_t          stb
);

  logic hitChange, hitIrq, hitInport, hitSet, hitClr;

  always_comb begin
    hitChange = (busAddr == OFF_CHANGE);
    hitIrq    = (busAddr == OFF_IRQ);
    hitInport = (busAddr == OFF_INPORT);
    hitSet    = (busAddr == OFF_OPSET);
    hitClr    = (busAddr == OFF_OPCLR);
  end

  always_comb begin
    stb           = '0;
    stb.wrMask    = busWr & hitIrq;
    stb.wrCfg     = busWr & hitInport;
    stb.setOut    = busWr & hitSet;
    stb.clrOut    = busWr & hitClr;
    stb.rdEn      = busRd;
    stb.clrChange = busRd & hitChange;
    stb.ctrStart  = busRd & hitSet;
    if (hitIrq)         stb.rdSel = RD_STATUS;
    else if (hitChange) stb.rdSel = RD_CHANGE;
    else if (hitInport) stb.rdSel = RD_INPORT;
    else                stb.rdSel = RD_NONE;
  end

endmodule

// File: rtl/irq_outport_dp.sv
module irq_outport_dp
  import irq_outport_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned IN_W        = 6,
  parameter int unsigned OUT_W       = 8,
  parameter int unsigned CHG_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [NUM_CH-1:0] chanTxRdy,
  input  logic [NUM_CH-1:0] chanRxRdy,
  input  logic [IN_W-1:0]   inPins,
  output logic [BUS_W-1:0]  rdata,
  output logic [OUT_W-1:0]  outPins,
  output logic [BUS_W-1:0]  opCfg,
  output logic              ctrStart,
  output logic              irqN
);

  localparam int unsigned STAT_W = 4 * NUM_CH;
  localparam int unsigned HALF   = BUS_W / 2;

  // Interrupt status: one 4-bit group per channel
  logic [STAT_W-1:0] statusVec;
  logic [STAT_W-1:0] maskReg;
  logic              irqQ;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    assign statusVec[4*ch]       = chanTxRdy[ch];
    assign statusVec[4*ch+1]     = chanRxRdy[ch];
    assign statusVec[4*ch+3 -: 2] = 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      irqQ    <= 1'b0;
    end else begin
      if (stb.wrMask) maskReg <= wdata[STAT_W-1:0];
      irqQ <= |(statusVec & maskReg);
    end
  end

  assign irqN = ~irqQ;

  // Output port: set/clear only, pins inverted
  logic [OUT_W-1:0] opReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opReg <= '0;
      opCfg <= '0;
    end else begin
      if (stb.setOut) opReg <= opReg | wdata[OUT_W-1:0];
      else if (stb.clrOut) opReg <= opReg & ~wdata[OUT_W-1:0];
      if (stb.wrCfg) opCfg <= wdata;
    end
  end

  assign outPins = ~opReg;

  // Input pin synchroniser, idle level high
  logic [IN_W-1:0] syncPipe [SYNC_STAGES];
  logic [IN_W-1:0] pinsNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '1;
    end else begin
      syncPipe[0] <= inPins;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
    end
  end

  assign pinsNow = syncPipe[SYNC_STAGES-1];

  // Change detection on the low pins; a new edge wins over the clearing read
  logic [CHG_PINS-1:0] pinsPrev;
  logic [CHG_PINS-1:0] chgFlags;
  logic [CHG_PINS-1:0] chgEdge;

  assign chgEdge = pinsNow[CHG_PINS-1:0] ^ pinsPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinsPrev <= '1;
      chgFlags <= '0;
    end else begin
      pinsPrev <= pinsNow[CHG_PINS-1:0];
      chgFlags <= (chgFlags & ~{CHG_PINS{stb.clrChange}}) | chgEdge;
    end
  end

  // Read word assembly
  logic [BUS_W-1:0] statusWord, changeWord, inportWord, rdNext;

  always_comb begin
    statusWord                   = '0;
    statusWord[STAT_W-1:0]       = statusVec;
    changeWord                   = '0;
    changeWord[CHG_PINS-1:0]     = pinsNow[CHG_PINS-1:0];
    changeWord[HALF +: CHG_PINS] = chgFlags;
    inportWord                   = '0;
    inportWord[IN_W-1:0]         = pinsNow;
    unique case (stb.rdSel)
      RD_STATUS: rdNext = statusWord;
      RD_CHANGE: rdNext = changeWord;
      RD_INPORT: rdNext = inportWord;
      default:   rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdata    <= '0;
      ctrStart <= 1'b0;
    end else begin
      if (stb.rdEn) rdata <= rdNext;
      ctrStart <= stb.ctrStart;
    end
  end

endmodule

// File: rtl/irq_outport_unit.sv
module irq_outport_unit
  import irq_outport_pkg::*;
#(
  parameter int unsigned NUM_CH      = 2,
  parameter int unsigned IN_W        = 6,
  parameter int unsigned OUT_W       = 8,
  parameter int unsigned CHG_PINS    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [NUM_CH-1:0] chanTxRdy,
  input  logic [NUM_CH-1:0] chanRxRdy,
  input  logic [IN_W-1:0]   inPins,
  output logic [OUT_W-1:0]  outPins,
  output logic [7:0]        opCfg,
  output logic              ctrStart,
  output logic              irqN
);

  strobes_t stb;

  irq_outport_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWr   (busWr),
    .busRd   (busRd),
    .stb     (stb)
  );

  irq_outport_dp #(
    .NUM_CH      (NUM_CH),
    .IN_W        (IN_W),
    .OUT_W       (OUT_W),
    .CHG_PINS    (CHG_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .wdata     (busWdata),
    .chanTxRdy (chanTxRdy),
    .chanRxRdy (chanRxRdy),
    .inPins    (inPins),
    .rdata     (busRdata),
    .outPins   (outPins),
    .opCfg     (opCfg),
    .ctrStart  (ctrStart),
    .irqN      (irqN)
  );

endmodule

// File: rtl/irq_outport_chk.sv
module irq_outport_chk #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned OUT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic [7:0]        busRdata,
  input logic [NUM_CH-1:0] chanTxRdy,
  input logic [NUM_CH-1:0] chanRxRdy,
  input logic [OUT_W-1:0]  outPins,
  input logic              ctrStart,
  input logic              irqN
);

  logic anySrc, wrSet, wrClr, rdSet;
  assign anySrc = |{chanTxRdy, chanRxRdy};
  assign wrSet  = busWr && (busAddr == 4'hE);
  assign wrClr  = busWr && (busAddr == 4'hF);
  assign rdSet  = busRd && (busAddr == 4'hE);

  AST_IRQ_NEEDS_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !irqN |-> $past(anySrc)); // R3
  AST_IRQ_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !anySrc |=> irqN); // R3
  AST_STATUS_CH0: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 4'h5) |=> busRdata[1:0] == $past({chanRxRdy[0], chanTxRdy[0]})); // R1
  AST_OUT_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrSet |=> (~outPins) == ($past(~outPins) | $past(busWdata[OUT_W-1:0]))); // R4
  AST_OUT_CLR: assert property (@(posedge clk) disable iff (!rstN)
    wrClr |=> (~outPins) == ($past(~outPins) & ~$past(busWdata[OUT_W-1:0]))); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrSet || wrClr) |=> $stable(outPins)); // R6
  AST_CTR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdSet |=> ctrStart); // R9
  AST_CTR_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdSet |=> !ctrStart); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata)); // R10

endmodule

bind irq_outport_unit irq_outport_chk #(
  .NUM_CH (NUM_CH),
  .OUT_W  (OUT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busAddr   (busAddr),
  .busWr     (busWr),
  .busRd     (busRd),
  .busWdata  (busWdata),
  .busRdata  (busRdata),
  .chanTxRdy (chanTxRdy),
  .chanRxRdy (chanRxRdy),
  .outPins   (outPins),
  .ctrStart  (ctrStart),
  .irqN      (irqN)
);

// File: tb/irq_outport_unit_tb_top.sv
module irq_outport_unit_tb_top;

  localparam int NUM_CH = 2;
  localparam int IN_W   = 6;
  localparam int OUT_W  = 8;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [3:0]        busAddr = '0;
  logic              busWr = 1'b0;
  logic              busRd = 1'b0;
  logic [7:0]        busWdata = '0;
  logic [7:0]        busRdata;
  logic [NUM_CH-1:0] chanTxRdy = '0;
  logic [NUM_CH-1:0] chanRxRdy = '0;
  logic [IN_W-1:0]   inPins = '1;
  logic [OUT_W-1:0]  outPins;
  logic [7:0]        opCfg;
  logic              ctrStart;
  logic              irqN;

  always #10 clk = ~clk;

  irq_outport_unit #(.NUM_CH(NUM_CH), .IN_W(IN_W), .OUT_W(OUT_W)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .chanTxRdy(chanTxRdy),
    .chanRxRdy(chanRxRdy), .inPins(inPins), .outPins(outPins), .opCfg(opCfg),
    .ctrStart(ctrStart), .irqN(irqN)
  );

  int    nCompared = 0;
  int    nMismatch = 0;
  bit    finished  = 1'b0;
  logic [7:0] expQ[$];
  string      reqQ[$];
  logic       rdSeen = 1'b0;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nCompared++;
    if (act !== exp) begin
      nMismatch++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  endtask

  // Scoreboard monitor: one expected item per completed read
  always @(posedge clk) rdSeen <= busRd;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        check("R10 unexpected read", busRdata, 8'hxx);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string r = reqQ.pop_front();
        check(r, busRdata, e);
      end
    end
  end

  task automatic busWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, input logic [7:0] exp, input string req);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    expQ.push_back(exp); reqQ.push_back(req);
    @(negedge clk);
    busRd = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nMismatch++;
    $display("FAIL watchdog expired actual=%h expected=%h", 8'h00, 8'h01);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 outPins after reset", outPins, 8'hFF);
    check("R11 irqN after reset", {7'd0, irqN}, 8'h01);
    check("R11 opCfg after reset", opCfg, 8'h00);
    check("R11 rdata after reset", busRdata, 8'h00);
    check("R11 ctrStart after reset", {7'd0, ctrStart}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);

    // R1 status layout
    chanTxRdy = 2'b01;
    busRead(4'h5, 8'h01, "R1 tx0 at bit0");
    chanTxRdy = 2'b10; chanRxRdy = 2'b10;
    busRead(4'h5, 8'h30, "R1 channel1 at bits 4,5");
    chanTxRdy = 2'b11; chanRxRdy = 2'b01;
    busRead(4'h5, 8'h13, "R1 mixed pattern");
    @(negedge clk);
    check("R3 mask zero keeps irqN high", {7'd0, irqN}, 8'h01);

    // R2 mask write, status read back
    chanTxRdy = 2'b01; chanRxRdy = 2'b00;
    busWrite(4'h5, 8'h02);
    busRead(4'h5, 8'h01, "R2 read returns status not mask");
    @(negedge clk);
    check("R3 masked-out source keeps irqN high", {7'd0, irqN}, 8'h01);
    chanRxRdy = 2'b01;
    @(negedge clk);
    check("R3 unmasked rx0 drives irqN low", {7'd0, irqN}, 8'h00);
    chanRxRdy = 2'b00;
    @(negedge clk);
    check("R3 irqN releases when source clears", {7'd0, irqN}, 8'h01);
    busWrite(4'h5, 8'h10);
    chanTxRdy = 2'b10;
    @(negedge clk);
    check("R3 channel1 tx bit4 unmasked", {7'd0, irqN}, 8'h00);
    chanTxRdy = 2'b00;
    @(negedge clk);
    check("R3 channel1 release", {7'd0, irqN}, 8'h01);

    // R4, R5 output port
    busWrite(4'hE, 8'hA5);
    check("R4 set pattern", outPins, 8'h5A);
    busWrite(4'hE, 8'h02);
    check("R4 zero bits unchanged", outPins, 8'h58);
    busWrite(4'hF, 8'h21);
    check("R5 clear pattern", outPins, 8'h79);

    // R6, R7 config write does not move outputs
    busWrite(4'hD, 8'h3C);
    check("R7 opCfg stored", opCfg, 8'h3C);
    check("R6 config write leaves outPins", outPins, 8'h79);
    busWrite(4'h5, 8'hFF);
    check("R6 mask write leaves outPins", outPins, 8'h79);
    busWrite(4'h5, 8'h00);

    // R7 input port, R8 change register
    @(negedge clk);
    inPins = 6'h2A;
    repeat (4) @(negedge clk);
    busRead(4'hD, 8'h2A, "R7 raw input pins");
    busRead(4'h4, 8'h5A, "R8 flags for pins 0 and 2");
    busRead(4'h4, 8'h0A, "R8 flags cleared by read");

    // R8 edge coinciding with the clearing read
    @(negedge clk);
    inPins = 6'h28;
    @(negedge clk);
    busRead(4'h4, 8'h08, "R8 read during new edge");
    busRead(4'h4, 8'h28, "R8 coincident edge kept");
    busRead(4'h4, 8'h08, "R8 cleared afterwards");

    // R9 counter start with simultaneous set
    @(negedge clk);
    busAddr = 4'hE; busWdata = 8'h40; busRd = 1'b1; busWr = 1'b1;
    expQ.push_back(8'h00); reqQ.push_back("R10 read at 0xE is 0");
    @(negedge clk);
    busRd = 1'b0; busWr = 1'b0;
    check("R9 ctrStart pulse", {7'd0, ctrStart}, 8'h01);
    check("R9 simultaneous set applied", outPins, 8'h39);
    @(negedge clk);
    check("R9 ctrStart one cycle only", {7'd0, ctrStart}, 8'h00);

    // R10 unmapped read and hold
    busRead(4'h3, 8'h00, "R10 unmapped reads 0");
    busRead(4'hD, 8'h28, "R10 inport before hold");
    repeat (3) @(negedge clk);
    check("R10 rdata holds without read", busRdata, 8'h28);

    repeat (3) @(negedge clk);
    check("R10 scoreboard drained", 8'(expQ.size()), 8'h00);
    finishRun();
  end

endmodule